// File: doc/BRIEF.md
# E1 CRC-4 Interworking Controller

This block decides, for one E1 receive direction, whether the link runs with CRC-4 multiframing toward the far end or falls back to plain framing. It does not frame the line or compute CRC remainders. It watches the framer's basic alignment status, its CRC-4 multiframe lock indication and its per-submultiframe CRC check results. From these and four control bits it produces the outgoing remote alarm bit, the two outgoing E-bits, a request to restart the basic alignment search, two status bits, and an enable for receive CRC checking.

When basic alignment is first acquired, a search phase starts. Within a window of 3200 frame strobes (400 ms), a reframe is requested every 64 strobes (8 ms) until multiframe lock is reported. If lock arrives inside the window, CRC-4 mode is entered. If the window runs out with automatic interworking enabled, the block commits to CRC-to-non-CRC operation, and that decision survives any later lock. If automatic interworking is disabled, the block instead holds the remote alarm high until lock arrives. A manual alarm override pins the remote alarm bit to a chosen level. Losing basic alignment, or flipping the interworking-disable bit, restarts everything from the no-alignment state.

Top module: `e1_crc4_iw`

## Requirements
- R1: During and after reset, and whenever basic alignment is absent, the block is idle: reframe_req=0, crc_sync_n=1, iw_crc=0, rx_crc_en=0, both E-bits equal ebit_idle, and tx_rai=1 unless the override is on.
- R2: While searching, reframe_req pulses high for exactly one cycle on the edge that counts the 64th, 128th, … frame strobe since the search began. The strobe that ends the window gives no pulse. In this count, entering the search takes one edge and each counted strobe takes one edge.
- R3: While searching with iw_disable=0 and rai_manual=0, tx_rai equals reframe_req. With iw_disable=1, tx_rai stays 0 while searching.
- R4: Multiframe lock (mf_found=1) seen while searching gives CRC-4 mode on the next cycle: crc_sync_n=0, iw_crc=1, rx_crc_en=1, tx_rai=0 (without override). iw_crc is also 1 throughout the search.
- R5: With iw_disable=0, if the 3200th frame strobe of the search passes without lock, the block switches on that edge to non-CRC mode: iw_crc=0, rx_crc_en=0, tx_rai=0.
- R6: In non-CRC mode, a later mf_found=1 drives crc_sync_n to 0 on the next cycle. iw_crc and rx_crc_en stay 0, and the mode does not change.
- R7: With iw_disable=1, when the window runs out without lock, tx_rai=1 and iw_crc=1 until mf_found=1. CRC-4 mode then follows on the next cycle with tx_rai=0.
- R8: With rai_manual=1, tx_rai equals rai_level in every state, in the same cycle.
- R9: Outside CRC-4 mode, tx_ebit = {ebit_idle, ebit_idle} in the same cycle, and CRC reports are ignored.
- R10: In CRC-4 mode, a report strobe with crc_rep_smf=i sets tx_ebit[i] to !crc_rep_bad from the next cycle. The other bit keeps its value. Both bits start at 1 on entry.
- R11: Loss of basic alignment, or a change of iw_disable, sends the block to the idle state on the next edge. This clears any non-CRC decision, and the window restarts from zero once alignment is present.
- R12: The search counters advance only on edges where frame_tick=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe per 125 us frame |
| fas_locked | input | 1 | Basic frame alignment held by the framer |
| mf_found | input | 1 | CRC-4 multiframe alignment found |
| crc_rep_stb | input | 1 | A submultiframe CRC check result is valid |
| crc_rep_smf | input | 1 | Which submultiframe the result belongs to (0 or 1) |
| crc_rep_bad | input | 1 | The checked submultiframe had a CRC error |
| iw_disable | input | 1 | 1 turns automatic interworking off |
| rai_manual | input | 1 | 1 forces tx_rai to rai_level |
| rai_level | input | 1 | Forced remote alarm level |
| ebit_idle | input | 1 | E-bit level sent while not in CRC-4 mode |
| tx_rai | output | 1 | Outgoing remote alarm indication |
| tx_ebit | output | 2 | Outgoing E-bits, index = submultiframe |
| reframe_req | output | 1 | Request for a new basic alignment search |
| crc_sync_n | output | 1 | 0 when multiframe lock has been reached |
| iw_crc | output | 1 | 1 while CRC-to-CRC operation is held or attempted |
| rx_crc_en | output | 1 | Receive CRC-4 checking enabled |

## Verification
Mode changes, reframe pulses, status bits and the CRC-mode E-bits all come from registers. Each therefore appears one rising edge after the input that causes it: the alignment change, the lock, the counted frame strobe or the CRC report. tx_rai under override and the idle E-bit level follow their control inputs in the same cycle. The bench drives every input just after a falling edge and lets its behavioural model advance on the rising edge. It then compares all outputs on the following falling edge. Directed checks count edges from the stimulus, so the 64th and 3200th strobe boundaries are sampled exactly on the cycle before and the cycle of the change.

// File: rtl/e1iw_pkg.sv
package e1iw_pkg;
  typedef enum logic [2:0] {
    IW_NOFAS,   // no basic alignment
    IW_SEARCH,  // interworking window running
    IW_CRC,     // CRC-4 multiframe mode
    IW_NONCRC,  // committed CRC-to-non-CRC
    IW_WAIT     // window expired, interworking off, awaiting lock
  } iw_state_t;
endpackage

// File: rtl/e1iw_frame_timer.sv
module e1iw_frame_timer #(
  parameter int RETRY_FRAMES  = 64,
  parameter int WINDOW_FRAMES = 3200
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic retry_hit,
  output logic win_hit
);
  localparam int RW = (RETRY_FRAMES > 1) ? $clog2(RETRY_FRAMES) : 1;
  localparam int CW = (WINDOW_FRAMES > 1) ? $clog2(WINDOW_FRAMES) : 1;
  localparam logic [RW-1:0] RETRY_LAST = RW'(RETRY_FRAMES - 1);
  localparam logic [CW-1:0] WIN_LAST   = CW'(WINDOW_FRAMES - 1);

  logic [RW-1:0] rty_q;
  logic [CW-1:0] frm_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      rty_q <= '0;
      frm_q <= '0;
    end else if (tick) begin
      frm_q <= frm_q + 1'b1;
      rty_q <= (rty_q == RETRY_LAST) ? '0 : rty_q + 1'b1;
    end
  end

  assign retry_hit = run & tick & (rty_q == RETRY_LAST);
  assign win_hit   = run & tick & (frm_q == WIN_LAST);

  // R2
  retry_single_chk: assert property (@(posedge clk) disable iff (rst)
    retry_hit |=> !retry_hit);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && $past(run)) |=> (frm_q == $past(frm_q)));
endmodule

// File: rtl/e1iw_ctrl.sv
module e1iw_ctrl
  import e1iw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fas_locked,
  input  logic      mf_found,
  input  logic      iw_disable,
  input  logic      retry_hit,
  input  logic      win_hit,
  output iw_state_t state_q,
  output logic      autc_q,
  output logic      reframe_q,
  output logic      mf_late_q
);
  iw_state_t state_d;
  logic      abort;

  always_comb begin
    abort   = !fas_locked || (iw_disable != autc_q);
    state_d = state_q;
    if (abort) begin
      state_d = IW_NOFAS;
    end else begin
      case (state_q)
        IW_NOFAS:  state_d = IW_SEARCH;
        IW_SEARCH: begin
          if (mf_found)     state_d = IW_CRC;
          else if (win_hit) state_d = iw_disable ? IW_WAIT : IW_NONCRC;
        end
        IW_WAIT:   if (mf_found) state_d = IW_CRC;
        IW_CRC:    state_d = IW_CRC;
        IW_NONCRC: state_d = IW_NONCRC;
        default:   state_d = IW_NOFAS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= IW_NOFAS;
      autc_q    <= 1'b0;
      reframe_q <= 1'b0;
      mf_late_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      autc_q    <= iw_disable;
      reframe_q <= (state_q == IW_SEARCH) && !abort && !mf_found && retry_hit && !win_hit;
      mf_late_q <= (state_d == IW_NONCRC) &&
                   (mf_late_q || ((state_q == IW_NONCRC) && mf_found));
    end
  end

  // R5
  expire_noncrc_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == IW_SEARCH && win_hit && !mf_found && !abort && !iw_disable)
      |=> (state_q == IW_NONCRC));

  // R6
  noncrc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == IW_NONCRC && fas_locked && iw_disable == autc_q)
      |=> (state_q == IW_NONCRC));

  // R11
  fas_loss_chk: assert property (@(posedge clk) disable iff (rst)
    !fas_locked |=> (state_q == IW_NOFAS));
endmodule

// File: rtl/e1iw_ebit.sv
module e1iw_ebit (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_crc,
  input  logic       err_stb,
  input  logic       err_idx,
  input  logic       err_bad,
  output logic [1:0] ebit_q
);
  always_ff @(posedge clk) begin
    if (rst || !in_crc) begin
      ebit_q <= 2'b11;
    end else if (err_stb) begin
      ebit_q[err_idx] <= !err_bad;
    end
  end

  // R10
  ebit_err_chk: assert property (@(posedge clk) disable iff (rst)
    (in_crc && err_stb && err_bad) |=> (!in_crc || !ebit_q[$past(err_idx)]));

  // R10
  ebit_other_chk: assert property (@(posedge clk) disable iff (rst)
    (in_crc && err_stb && $past(in_crc)) |=> (!in_crc || ebit_q[!$past(err_idx)] == $past(ebit_q[!err_idx])));
endmodule

// File: rtl/e1_crc4_iw.sv
module e1_crc4_iw
  import e1iw_pkg::*;
#(
  parameter int RETRY_FRAMES  = 64,
  parameter int WINDOW_FRAMES = 3200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_tick,
  input  logic       fas_locked,
  input  logic       mf_found,
  input  logic       crc_rep_stb,
  input  logic       crc_rep_smf,
  input  logic       crc_rep_bad,
  input  logic       iw_disable,
  input  logic       rai_manual,
  input  logic       rai_level,
  input  logic       ebit_idle,
  output logic       tx_rai,
  output logic [1:0] tx_ebit,
  output logic       reframe_req,
  output logic       crc_sync_n,
  output logic       iw_crc,
  output logic       rx_crc_en
);
  iw_state_t  state_q;
  logic       autc_q, reframe_q, mf_late_q;
  logic       retry_hit, win_hit;
  logic       in_crc;
  logic [1:0] ebit_q;

  e1iw_frame_timer #(
    .RETRY_FRAMES (RETRY_FRAMES),
    .WINDOW_FRAMES(WINDOW_FRAMES)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (state_q == IW_SEARCH),
    .tick     (frame_tick),
    .retry_hit(retry_hit),
    .win_hit  (win_hit)
  );

  e1iw_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .fas_locked(fas_locked),
    .mf_found  (mf_found),
    .iw_disable(iw_disable),
    .retry_hit (retry_hit),
    .win_hit   (win_hit),
    .state_q   (state_q),
    .autc_q    (autc_q),
    .reframe_q (reframe_q),
    .mf_late_q (mf_late_q)
  );

  assign in_crc = (state_q == IW_CRC);

  e1iw_ebit u_ebit (
    .clk    (clk),
    .rst    (rst),
    .in_crc (in_crc),
    .err_stb(crc_rep_stb),
    .err_idx(crc_rep_smf),
    .err_bad(crc_rep_bad),
    .ebit_q (ebit_q)
  );

  always_comb begin
    if (rai_manual) begin
      tx_rai = rai_level;
    end else begin
      case (state_q)
        IW_NOFAS:  tx_rai = 1'b1;
        IW_WAIT:   tx_rai = 1'b1;
        IW_SEARCH: tx_rai = reframe_q & !autc_q;
        default:   tx_rai = 1'b0;
      endcase
    end
    tx_ebit     = in_crc ? ebit_q : {2{ebit_idle}};
    reframe_req = reframe_q;
    crc_sync_n  = !(in_crc || ((state_q == IW_NONCRC) && mf_late_q));
    iw_crc      = (state_q == IW_SEARCH) || in_crc || (state_q == IW_WAIT);
    rx_crc_en   = in_crc;
  end

  // R4
  crc_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_crc_en) |-> ($past(mf_found) && !crc_sync_n && iw_crc));

  // R7
  wait_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == IW_WAIT && mf_found && fas_locked && iw_disable == autc_q)
      |=> rx_crc_en);
endmodule

// File: tb/e1_crc4_iw_tb.sv
`timescale 1ns/1ps
module e1_crc4_iw_tb;
  localparam int R = 64;
  localparam int W = 3200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 1'b1, fas_locked = 1'b0, mf_found = 1'b0;
  logic crc_rep_stb = 1'b0, crc_rep_smf = 1'b0, crc_rep_bad = 1'b0;
  logic iw_disable = 1'b0, rai_manual = 1'b0, rai_level = 1'b0, ebit_idle = 1'b1;
  logic tx_rai, reframe_req, crc_sync_n, iw_crc, rx_crc_en;
  logic [1:0] tx_ebit;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit tick_half = 1'b0;

  always #10 clk = ~clk;

  e1_crc4_iw #(.RETRY_FRAMES(R), .WINDOW_FRAMES(W)) u_dut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .fas_locked(fas_locked),
    .mf_found(mf_found), .crc_rep_stb(crc_rep_stb), .crc_rep_smf(crc_rep_smf),
    .crc_rep_bad(crc_rep_bad), .iw_disable(iw_disable), .rai_manual(rai_manual),
    .rai_level(rai_level), .ebit_idle(ebit_idle), .tx_rai(tx_rai), .tx_ebit(tx_ebit),
    .reframe_req(reframe_req), .crc_sync_n(crc_sync_n), .iw_crc(iw_crc),
    .rx_crc_en(rx_crc_en)
  );

  // behavioural model: 0 idle, 1 search, 2 crc, 3 non-crc, 4 wait
  int m_st = 0, m_frm = 0, m_rty = 0;
  bit m_refr = 0, m_late = 0, m_autc = 0;
  bit [1:0] m_eb = 2'b11;

  always @(posedge clk) begin
    int  nst;
    bit  nref, ab;
    if (rst) begin
      m_st = 0; m_frm = 0; m_rty = 0; m_refr = 0; m_late = 0; m_autc = 0; m_eb = 2'b11;
    end else begin
      nref = 0;
      ab   = !fas_locked || (iw_disable != m_autc);
      nst  = m_st;
      if (ab) nst = 0;
      else if (m_st == 0) nst = 1;
      else if (m_st == 1) begin
        if (mf_found) nst = 2;
        else if (frame_tick && m_frm == W - 1) nst = iw_disable ? 4 : 3;
        else if (frame_tick && m_rty == R - 1) nref = 1;
      end else if (m_st == 4 && mf_found) nst = 2;
      if (m_st == 2 && crc_rep_stb) m_eb[crc_rep_smf] = !crc_rep_bad;
      else if (m_st != 2) m_eb = 2'b11;
      if (m_st == 1 && frame_tick) begin
        m_frm++;
        m_rty = (m_rty == R - 1) ? 0 : m_rty + 1;
      end else if (m_st != 1) begin
        m_frm = 0; m_rty = 0;
      end
      m_late = (nst == 3) && (m_late || (m_st == 3 && mf_found));
      m_refr = nref;
      m_autc = iw_disable;
      m_st   = nst;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int e_rai;
    e_rai = rai_manual ? int'(rai_level) :
            (m_st == 0 || m_st == 4) ? 1 :
            (m_st == 1) ? int'(m_refr && !m_autc) : 0;
    chk("R3 tx_rai model", int'(tx_rai), e_rai);
    chk("R2 reframe_req model", int'(reframe_req), int'(m_refr));
    chk("R6 crc_sync_n model", int'(crc_sync_n), int'(!(m_st == 2 || (m_st == 3 && m_late))));
    chk("R5 iw_crc model", int'(iw_crc), int'(m_st == 1 || m_st == 2 || m_st == 4));
    chk("R4 rx_crc_en model", int'(rx_crc_en), int'(m_st == 2));
    chk("R10 tx_ebit model", int'(tx_ebit), (m_st == 2) ? int'(m_eb) : int'({ebit_idle, ebit_idle}));
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cmp_on) compare();
      frame_tick = tick_half ? ~frame_tick : 1'b1;
    end
  endtask

  initial begin
    #(200000 * 20);
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors + 1);
    $finish;
  end

  initial begin
    int pulses;
    step(3);
    // R1 reset state
    chk("R1 rai", tx_rai, 1); chk("R1 reframe", reframe_req, 0);
    chk("R1 sync_n", crc_sync_n, 1); chk("R1 iw", iw_crc, 0);
    chk("R1 en", rx_crc_en, 0); chk("R1 ebit", tx_ebit, 3);
    rst = 1'b0; cmp_on = 1'b1;
    step(2);
    chk("R1 idle rai", tx_rai, 1);

    // R2 / R3: retry pulse with interworking on
    fas_locked = 1'b1;
    step(64);
    chk("R2 before 64th", reframe_req, 0);
    step(1);
    chk("R2 at 64th", reframe_req, 1); chk("R3 flicker", tx_rai, 1);
    step(1);
    chk("R2 single", reframe_req, 0); chk("R3 low", tx_rai, 0);

    // R5 window expiry
    step(3134);
    chk("R5 still searching", iw_crc, 1);
    step(1);
    chk("R5 iw", iw_crc, 0); chk("R5 en", rx_crc_en, 0); chk("R5 rai", tx_rai, 0);
    chk("R2 no pulse at end", reframe_req, 0);

    // R9 idle E-bits, reports ignored
    ebit_idle = 1'b0; crc_rep_stb = 1'b1; crc_rep_smf = 1'b0; crc_rep_bad = 1'b0;
    step(1);
    crc_rep_stb = 1'b0;
    chk("R9 ebit", tx_ebit, 0); chk("R6 before lock", crc_sync_n, 1);

    // R6 late lock
    mf_found = 1'b1;
    step(1);
    chk("R6 sync_n", crc_sync_n, 0); chk("R6 iw", iw_crc, 0); chk("R6 en", rx_crc_en, 0);
    step(5);
    chk("R6 sticky", iw_crc, 0);

    // R11 interworking toggle, then R7
    iw_disable = 1'b1; mf_found = 1'b0;
    step(1);
    chk("R11 idle iw", iw_crc, 0); chk("R11 idle rai", tx_rai, 1);
    step(1);
    chk("R11 restart iw", iw_crc, 1); chk("R11 sync_n", crc_sync_n, 1);
    step(64);
    chk("R3 pulse off", reframe_req, 1); chk("R3 rai quiet", tx_rai, 0);
    step(3135);
    chk("R7 before expiry", tx_rai, 0);
    step(1);
    chk("R7 rai", tx_rai, 1); chk("R7 iw", iw_crc, 1); chk("R7 en", rx_crc_en, 0);
    chk("R9 wait ebit", tx_ebit, 0);
    step(20);
    chk("R7 hold", tx_rai, 1);
    mf_found = 1'b1;
    step(1);
    chk("R7 lock rai", tx_rai, 0); chk("R7 lock en", rx_crc_en, 1);
    chk("R7 lock sync", crc_sync_n, 0); chk("R10 entry", tx_ebit, 3);

    // R10 E-bits from CRC reports
    crc_rep_stb = 1'b1; crc_rep_smf = 1'b1; crc_rep_bad = 1'b1;
    step(1);
    chk("R10 err smf1", tx_ebit, 1);
    crc_rep_smf = 1'b0; crc_rep_bad = 1'b0;
    step(1);
    chk("R10 smf0 ok", tx_ebit, 1);
    crc_rep_smf = 1'b1;
    step(1);
    crc_rep_stb = 1'b0;
    chk("R10 smf1 ok", tx_ebit, 3);

    // R8 override
    rai_manual = 1'b1; rai_level = 1'b1;
    step(1);
    chk("R8 high", tx_rai, 1);
    rai_level = 1'b0;
    step(1);
    chk("R8 low", tx_rai, 0);
    rai_manual = 1'b0;

    // R11 alignment loss
    fas_locked = 1'b0;
    step(1);
    chk("R11 en", rx_crc_en, 0); chk("R11 iw", iw_crc, 0); chk("R11 rai", tx_rai, 1);
    chk("R9 idle", tx_ebit, 0);
    mf_found = 1'b0;

    // R4 lock inside the window
    fas_locked = 1'b1;
    step(11);
    chk("R4 searching", iw_crc, 1); chk("R4 not yet", rx_crc_en, 0);
    mf_found = 1'b1;
    step(1);
    chk("R4 sync_n", crc_sync_n, 0); chk("R4 iw", iw_crc, 1);
    chk("R4 en", rx_crc_en, 1); chk("R4 rai", tx_rai, 0);

    // R12 counting only on strobes
    fas_locked = 1'b0; mf_found = 1'b0;
    step(1);
    tick_half = 1'b1; fas_locked = 1'b1;
    pulses = 0;
    for (int i = 0; i < 140; i++) begin
      step(1);
      if (reframe_req) pulses++;
    end
    chk("R12 pulses", pulses, 1);
    tick_half = 1'b0;

    // R8 in idle
    rai_manual = 1'b1; rai_level = 1'b0; fas_locked = 1'b0;
    step(1);
    chk("R8 idle override", tx_rai, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule